// File: doc/BRIEF.md
# Noise-Driven Burst Frequency Hop Controller

This block watches the per-key deltas (signal minus reference) that a capacitive key matrix scanner produces on every scan. It decides whether the burst timing should move to another of three delay settings. Two saturating counters accumulate qualified noise: one for deltas above the noise threshold, one for deltas below its negative. A hop is granted at the end of a scan only when both counters have reached the noise limit, hopping is enabled and no calibration is running. Both counters then clear.

After a hop, the block asks for one of two follow-ups, chosen by the hop mode. It either requests a recalibration of every key, or it offers reference shifts taken from a per-key offset store. The store holds two clamped differences for each key: reference at setting 0 minus reference at setting 1, and reference at setting 0 minus reference at setting 2. A combinational port converts any key's reference from the previous setting to the current one, one key index at a time.

Top module: `freq_hop_ctrl`

## Requirements
- R1: After reset the active setting index is 0, `burst_dly_o` equals `freq0_dly_i`, and `hop_o`, `cal_req_o` and `adj_req_o` are low.
- R2: A sample counts as noise only when `sample_valid_i` is high, `sample_detect_i` is low and the magnitude of the signed delta is strictly greater than `noise_thr_i`. A positive delta feeds the positive counter and a negative delta feeds the negative counter. A delta equal to the threshold, or a sample taken while the key is in detect, has no effect.
- R3: Each noise counter saturates at 2^CNT_W-1 and does not wrap.
- R4: In a cycle with `scan_end_i` high, a hop is granted when both counters are at or above `noise_lim_i`. A sample in that same cycle is not counted. Both counters are zero in the following cycle.
- R5: A granted hop advances the index 0→1→2→0. `hop_o` pulses for one cycle, one clock after `scan_end_i`. In that same cycle `freq_idx_o` and `burst_dly_o` show the new setting (index 0, 1 or 2 selects `freq0_dly_i`, `freq1_dly_i` or `freq2_dly_i`).
- R6: No hop is granted while `cal_busy_i` is high at the end of a scan.
- R7: Hop mode 0 (and the unused code 3) never hops.
- R8: In mode 1 a hop also pulses `cal_req_o`. In mode 2 a hop also pulses `adj_req_o`. The two are never high together.
- R9: `ofs_wr_i` stores, for key `ofs_key_i`, max(ref_f0-ref_f1, 0) as offset 1 and max(ref_f0-ref_f2, 0) as offset 2. Writes to a key index ≥ NUM_KEYS are ignored, and reads of such an index see zero offsets.
- R10: `adj_ref_o` = clamp(`adj_ref_i` + off[prev] - off[cur], 0, 2^REF_W-1). Here off[0]=0, off[1] and off[2] are the key's stored offsets, and prev is the setting before the last hop (0 before any hop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hop_mode_i | input | 2 | 0 off, 1 recalibrate, 2 shift references |
| noise_thr_i | input | DELTA_W-1 | Noise magnitude threshold |
| noise_lim_i | input | CNT_W | Noise count limit |
| freq0_dly_i | input | DLY_W | Delay setting 0 |
| freq1_dly_i | input | DLY_W | Delay setting 1 |
| freq2_dly_i | input | DLY_W | Delay setting 2 |
| sample_valid_i | input | 1 | Delta sample strobe |
| sample_delta_i | input | DELTA_W | Signed delta |
| sample_detect_i | input | 1 | Sampled key is in detect |
| scan_end_i | input | 1 | End of matrix scan |
| cal_busy_i | input | 1 | Any key calibration running |
| ofs_wr_i | input | 1 | Offset store write |
| ofs_key_i | input | KEY_W | Key written |
| ref_f0_i | input | REF_W | Reference at setting 0 |
| ref_f1_i | input | REF_W | Reference at setting 1 |
| ref_f2_i | input | REF_W | Reference at setting 2 |
| adj_key_i | input | KEY_W | Key to convert |
| adj_ref_i | input | REF_W | Reference to convert |
| burst_dly_o | output | DLY_W | Active delay setting |
| freq_idx_o | output | 2 | Active setting index |
| hop_o | output | 1 | Hop pulse |
| cal_req_o | output | 1 | Recalibrate-all request |
| adj_req_o | output | 1 | Reference shift request |
| adj_ref_o | output | REF_W | Converted reference |

## Verification
Assertions check on every cycle that the index never takes code 3, that a hop moves exactly one step from the prior setting, that busy calibration or mode 0 at scan end blocks a hop, that counters clear after a scan end and hold at saturation, and that the two request pulses never coincide. The bench alone can show that noise qualification uses strict magnitude and ignores detect. It also shows that the limit comparison is correct at its boundary, that the offsets are clamped and combined correctly for every prev/current pair, and that the adjusted reference saturates at both ends.

// File: rtl/freq_hop_pkg.sv
package freq_hop_pkg;
  typedef enum logic [1:0] {
    HOP_OFF   = 2'd0,
    HOP_RECAL = 2'd1,
    HOP_SHIFT = 2'd2,
    HOP_RSVD  = 2'd3
  } hop_mode_e;

  localparam int unsigned NUM_SETTINGS = 3;

  function automatic logic [1:0] next_idx(input logic [1:0] idx);
    return (idx == 2'd2) ? 2'd0 : idx + 2'd1;
  endfunction
endpackage

// File: rtl/noise_counter.sv
module noise_counter #(
  parameter int unsigned DELTA_W = 16,
  parameter int unsigned CNT_W   = 8,
  parameter bit          NEG_DIR = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic               detect_i,
  input  logic [DELTA_W-2:0] thr_i,
  input  logic               clear_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic signed [DELTA_W:0] delta_ext, mag, thr_ext;
  logic hit;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    delta_ext = {delta_i[DELTA_W-1], delta_i};
    thr_ext   = {2'b00, thr_i};
    mag       = NEG_DIR ? -delta_ext : delta_ext;
    hit       = valid_i && !detect_i && (mag > thr_ext);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (hit && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r4_clear_after_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clear_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/hop_decider.sv
module hop_decider
  import freq_hop_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_end_i,
  input  logic [1:0]       mode_i,
  input  logic             cal_busy_i,
  input  logic [CNT_W-1:0] pos_cnt_i,
  input  logic [CNT_W-1:0] neg_cnt_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [1:0]       idx_o,
  output logic [1:0]       prev_idx_o,
  output logic             hop_o,
  output logic             cal_req_o,
  output logic             adj_req_o
);
  logic [1:0] idx_q, prev_q;
  logic hop_q, cal_q, adj_q;
  logic mode_on, hop_go;

  always_comb begin
    mode_on = (mode_i == HOP_RECAL) || (mode_i == HOP_SHIFT);
    hop_go  = scan_end_i && mode_on && !cal_busy_i &&
              (pos_cnt_i >= lim_i) && (neg_cnt_i >= lim_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= 2'd0;
      prev_q <= 2'd0;
      hop_q  <= 1'b0;
      cal_q  <= 1'b0;
      adj_q  <= 1'b0;
    end else begin
      hop_q <= hop_go;
      cal_q <= hop_go && (mode_i == HOP_RECAL);
      adj_q <= hop_go && (mode_i == HOP_SHIFT);
      if (hop_go) begin
        prev_q <= idx_q;
        idx_q  <= next_idx(idx_q);
      end
    end
  end

  assign idx_o      = idx_q;
  assign prev_idx_o = prev_q;
  assign hop_o      = hop_q;
  assign cal_req_o  = cal_q;
  assign adj_req_o  = adj_q;

  a_r5_idx_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q != 2'd3);
  a_r5_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_q |-> (idx_q == ((prev_q == 2'd2) ? 2'd0 : prev_q + 2'd1)));
  a_r5_hold_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_end_i |=> $stable(idx_q));
  a_r6_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_end_i && cal_busy_i) |=> !hop_q);
  a_r7_mode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_end_i && (mode_i == HOP_OFF || mode_i == HOP_RSVD)) |=> !hop_q);
  a_r8_req_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cal_q, adj_q}));
  a_r8_req_with_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_q || adj_q) |-> hop_q);
endmodule

// File: rtl/offset_store.sv
module offset_store #(
  parameter int unsigned NUM_KEYS = 48,
  parameter int unsigned REF_W    = 16,
  parameter int unsigned KEY_W    = $clog2(NUM_KEYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [REF_W-1:0] ref_f0_i,
  input  logic [REF_W-1:0] ref_f1_i,
  input  logic [REF_W-1:0] ref_f2_i,
  input  logic [KEY_W-1:0] rd_key_i,
  input  logic [REF_W-1:0] rd_ref_i,
  input  logic [1:0]       from_idx_i,
  input  logic [1:0]       to_idx_i,
  output logic [REF_W-1:0] adj_ref_o
);
  localparam int unsigned SW = REF_W + 2;
  localparam logic [KEY_W:0] KEY_LIM = (KEY_W+1)'(NUM_KEYS);
  localparam logic signed [SW-1:0] REF_MAX = SW'({REF_W{1'b1}});

  logic [REF_W-1:0] off1_q [NUM_KEYS];
  logic [REF_W-1:0] off2_q [NUM_KEYS];

  function automatic logic [REF_W-1:0] clamp_diff(input logic [REF_W-1:0] a,
                                                  input logic [REF_W-1:0] b);
    return (a > b) ? a - b : '0;
  endfunction

  logic wr_ok, rd_ok;
  logic [REF_W-1:0] rd_off1, rd_off2;
  logic signed [SW-1:0] off_from, off_to, sum;

  function automatic logic signed [SW-1:0] pick(input logic [1:0] idx,
                                                input logic [REF_W-1:0] o1,
                                                input logic [REF_W-1:0] o2);
    case (idx)
      2'd1:    return {2'b00, o1};
      2'd2:    return {2'b00, o2};
      default: return '0;
    endcase
  endfunction

  always_comb begin
    wr_ok    = {1'b0, wr_key_i} < KEY_LIM;
    rd_ok    = {1'b0, rd_key_i} < KEY_LIM;
    rd_off1  = rd_ok ? off1_q[rd_key_i] : '0;
    rd_off2  = rd_ok ? off2_q[rd_key_i] : '0;
    off_from = pick(from_idx_i, rd_off1, rd_off2);
    off_to   = pick(to_idx_i, rd_off1, rd_off2);
    sum      = {2'b00, rd_ref_i} + off_from - off_to;
    if (sum < 0)             adj_ref_o = '0;
    else if (sum > REF_MAX)  adj_ref_o = {REF_W{1'b1}};
    else                     adj_ref_o = sum[REF_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_KEYS; k++) begin
        off1_q[k] <= '0;
        off2_q[k] <= '0;
      end
    end else if (wr_i && wr_ok) begin
      off1_q[wr_key_i] <= clamp_diff(ref_f0_i, ref_f1_i);
      off2_q[wr_key_i] <= clamp_diff(ref_f0_i, ref_f2_i);
    end
  end

  a_r10_same_idx_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (from_idx_i == to_idx_i) |-> adj_ref_o == rd_ref_i);
  a_r9_off_le_f0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_ok) |=> off1_q[$past(wr_key_i)] <= $past(ref_f0_i));
endmodule

// File: rtl/freq_hop_ctrl.sv
module freq_hop_ctrl #(
  parameter int unsigned NUM_KEYS = 48,
  parameter int unsigned DELTA_W  = 16,
  parameter int unsigned REF_W    = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DLY_W    = 6,
  parameter int unsigned KEY_W    = $clog2(NUM_KEYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         hop_mode_i,
  input  logic [DELTA_W-2:0] noise_thr_i,
  input  logic [CNT_W-1:0]   noise_lim_i,
  input  logic [DLY_W-1:0]   freq0_dly_i,
  input  logic [DLY_W-1:0]   freq1_dly_i,
  input  logic [DLY_W-1:0]   freq2_dly_i,
  input  logic               sample_valid_i,
  input  logic [DELTA_W-1:0] sample_delta_i,
  input  logic               sample_detect_i,
  input  logic               scan_end_i,
  input  logic               cal_busy_i,
  input  logic               ofs_wr_i,
  input  logic [KEY_W-1:0]   ofs_key_i,
  input  logic [REF_W-1:0]   ref_f0_i,
  input  logic [REF_W-1:0]   ref_f1_i,
  input  logic [REF_W-1:0]   ref_f2_i,
  input  logic [KEY_W-1:0]   adj_key_i,
  input  logic [REF_W-1:0]   adj_ref_i,
  output logic [DLY_W-1:0]   burst_dly_o,
  output logic [1:0]         freq_idx_o,
  output logic               hop_o,
  output logic               cal_req_o,
  output logic               adj_req_o,
  output logic [REF_W-1:0]   adj_ref_o
);
  logic [CNT_W-1:0] cnt [2];
  logic [1:0] idx, prev_idx;
  logic cnt_valid;

  // samples arriving with scan_end are discarded
  assign cnt_valid = sample_valid_i && !scan_end_i;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    noise_counter #(
      .DELTA_W(DELTA_W),
      .CNT_W  (CNT_W),
      .NEG_DIR(d == 1)
    ) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (cnt_valid),
      .delta_i (sample_delta_i),
      .detect_i(sample_detect_i),
      .thr_i   (noise_thr_i),
      .clear_i (scan_end_i),
      .cnt_o   (cnt[d])
    );
  end

  hop_decider #(.CNT_W(CNT_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scan_end_i(scan_end_i),
    .mode_i    (hop_mode_i),
    .cal_busy_i(cal_busy_i),
    .pos_cnt_i (cnt[0]),
    .neg_cnt_i (cnt[1]),
    .lim_i     (noise_lim_i),
    .idx_o     (idx),
    .prev_idx_o(prev_idx),
    .hop_o     (hop_o),
    .cal_req_o (cal_req_o),
    .adj_req_o (adj_req_o)
  );

  offset_store #(
    .NUM_KEYS(NUM_KEYS),
    .REF_W   (REF_W),
    .KEY_W   (KEY_W)
  ) u_ofs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ofs_wr_i),
    .wr_key_i  (ofs_key_i),
    .ref_f0_i  (ref_f0_i),
    .ref_f1_i  (ref_f1_i),
    .ref_f2_i  (ref_f2_i),
    .rd_key_i  (adj_key_i),
    .rd_ref_i  (adj_ref_i),
    .from_idx_i(prev_idx),
    .to_idx_i  (idx),
    .adj_ref_o (adj_ref_o)
  );

  always_comb begin
    case (idx)
      2'd1:    burst_dly_o = freq1_dly_i;
      2'd2:    burst_dly_o = freq2_dly_i;
      default: burst_dly_o = freq0_dly_i;
    endcase
  end

  assign freq_idx_o = idx;

  a_r1_quiet_idx0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == 2'd0) |-> burst_dly_o == freq0_dly_i);
endmodule

// File: tb/freq_hop_ctrl_tb.sv
module freq_hop_ctrl_tb;
  localparam int NK = 48, DW = 16, RW = 16, CW = 8, LW = 6, KW = 6;
  localparam int RMAX = (1 << RW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] mode = '0;
  logic [DW-2:0] thr = '0;
  logic [CW-1:0] lim = '0;
  logic [LW-1:0] f0 = 6'd5, f1 = 6'd27, f2 = 6'd60;
  logic sv = 0, sdet = 0, se = 0, busy = 0, owr = 0;
  logic [DW-1:0] sdelta = '0;
  logic [KW-1:0] okey = '0, akey = '0;
  logic [RW-1:0] r0 = '0, r1 = '0, r2 = '0, aref = '0;
  logic [LW-1:0] dly;
  logic [1:0] fidx;
  logic hop, creq, areq;
  logic [RW-1:0] aout;

  freq_hop_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hop_mode_i(mode), .noise_thr_i(thr),
    .noise_lim_i(lim), .freq0_dly_i(f0), .freq1_dly_i(f1), .freq2_dly_i(f2),
    .sample_valid_i(sv), .sample_delta_i(sdelta), .sample_detect_i(sdet),
    .scan_end_i(se), .cal_busy_i(busy), .ofs_wr_i(owr), .ofs_key_i(okey),
    .ref_f0_i(r0), .ref_f1_i(r1), .ref_f2_i(r2), .adj_key_i(akey),
    .adj_ref_i(aref), .burst_dly_o(dly), .freq_idx_o(fidx), .hop_o(hop),
    .cal_req_o(creq), .adj_req_o(areq), .adj_ref_o(aout)
  );

  int n_chk = 0, n_fail = 0;
  int m_pos = 0, m_neg = 0, m_idx = 0, m_prev = 0;
  int m_o1 [NK], m_o2 [NK];
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_dly(input int i);
    return (i == 1) ? int'(f1) : (i == 2) ? int'(f2) : int'(f0);
  endfunction

  function automatic int off_of(input int key, input int i);
    if (key >= NK) return 0;
    return (i == 1) ? m_o1[key] : (i == 2) ? m_o2[key] : 0;
  endfunction

  // R2 R3: noise qualification and saturation model
  task automatic sample(input int d, input bit det);
    sv = 1; sdelta = DW'(d); sdet = det;
    @(negedge clk);
    sv = 0; sdet = 0;
    if (!det && d > int'(thr) && m_pos < CMAX) m_pos++;
    if (!det && -d > int'(thr) && m_neg < CMAX) m_neg++;
  endtask

  // R4 R5 R6 R7 R8
  task automatic end_scan(input bit b, input string tag);
    bit go;
    go = (mode == 2'd1 || mode == 2'd2) && !b &&
         m_pos >= int'(lim) && m_neg >= int'(lim);
    se = 1; busy = b;
    @(negedge clk);
    se = 0; busy = 0;
    if (go) begin m_prev = m_idx; m_idx = (m_idx + 1) % 3; end
    m_pos = 0; m_neg = 0;
    chk({tag, " R4 hop"}, int'(hop), int'(go));
    chk({tag, " R5 idx"}, int'(fidx), m_idx);
    chk({tag, " R5 dly"}, int'(dly), exp_dly(m_idx));
    chk({tag, " R8 cal_req"}, int'(creq), int'(go && mode == 2'd1));
    chk({tag, " R8 adj_req"}, int'(areq), int'(go && mode == 2'd2));
  endtask

  task automatic wr_ofs(input int key, input int a, input int b, input int c);
    owr = 1; okey = KW'(key); r0 = RW'(a); r1 = RW'(b); r2 = RW'(c);
    @(negedge clk);
    owr = 0;
    if (key < NK) begin
      m_o1[key] = (a > b) ? a - b : 0;
      m_o2[key] = (a > c) ? a - c : 0;
    end
  endtask

  // R9 R10
  task automatic chk_adj(input int key, input int r, input string tag);
    int e;
    akey = KW'(key); aref = RW'(r);
    #1;
    e = r + off_of(key, m_prev) - off_of(key, m_idx);
    if (e < 0) e = 0;
    if (e > RMAX) e = RMAX;
    chk({tag, " R10 adj_ref"}, int'(aout), e);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NK; k++) begin m_o1[k] = 0; m_o2[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idx", int'(fidx), 0);
    chk("R1 dly", int'(dly), int'(f0));
    chk("R1 hop", int'(hop) + int'(creq) + int'(areq), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 boundary: exact threshold and detect ignored
    mode = 2'd1; thr = 15'd50; lim = 8'd3;
    repeat (3) sample(51, 0);
    repeat (2) sample(-51, 0);
    sample(-50, 0); sample(-300, 1); sample(50, 0);
    end_scan(0, "R2 equal/detect no hop");
    repeat (3) sample(51, 0);
    repeat (3) sample(-51, 0);
    end_scan(0, "R2 limit reached");

    // R4 sample coincident with scan end is discarded
    repeat (3) sample(80, 0);
    repeat (2) sample(-80, 0);
    sv = 1; sdelta = DW'(-80);
    end_scan(0, "R4 same-cycle sample");
    sv = 0;
    end_scan(0, "R4 counters cleared");

    // R6 busy blocks, then counters cleared
    repeat (4) sample(90, 0);
    repeat (4) sample(-90, 0);
    end_scan(1, "R6 busy");
    end_scan(0, "R6 after busy");

    // R7 modes 0 and 3
    mode = 2'd0;
    repeat (4) sample(90, 0); repeat (4) sample(-90, 0);
    end_scan(0, "R7 mode0");
    mode = 2'd3;
    repeat (4) sample(90, 0); repeat (4) sample(-90, 0);
    end_scan(0, "R7 mode3");

    // R3 saturation at limit 255
    mode = 2'd2; lim = 8'd255; thr = 15'd0;
    repeat (300) sample(1, 0);
    repeat (300) sample(-1, 0);
    end_scan(0, "R3 saturate");

    // R9 offsets incl. negative clamp and out-of-range key
    wr_ofs(0, 1000, 900, 700);
    wr_ofs(1, 500, 800, 400);
    wr_ofs(2, 65000, 1000, 65000);
    wr_ofs(3, 65000, 65000, 100);
    wr_ofs(47, 300, 200, 900);
    wr_ofs(60, 9000, 10, 10);
    for (int k = 4; k < 12; k++)
      wr_ofs(k, int'($urandom_range(0, RMAX)), int'($urandom_range(0, RMAX)),
             int'($urandom_range(0, RMAX)));

    // random scans with adjust checks across all prev/cur pairs
    for (int s = 0; s < 60; s++) begin
      int ns;
      mode = 2'($urandom_range(0, 3));
      if (s % 4 != 3) mode = 2'($urandom_range(1, 2));
      thr = 15'($urandom_range(0, 200));
      lim = 8'($urandom_range(0, 6));
      ns  = int'($urandom_range(0, 25));
      for (int i = 0; i < ns; i++)
        sample(int'($urandom_range(0, 800)) - 400, ($urandom_range(0, 7) == 0));
      end_scan(($urandom_range(0, 7) == 0), "RND");
      chk_adj(0, 500, "R9 key0");
      chk_adj(1, 1000, "R9 key1 clamp");
      chk_adj(2, 100, "R10 low clamp");
      chk_adj(2, 65000, "R10 high clamp");
      chk_adj(3, 200, "R10 key3");
      chk_adj(47, int'($urandom_range(0, RMAX)), "R9 key47");
      chk_adj(60, 1234, "R9 out-of-range key");
      chk_adj(int'($urandom_range(4, 11)), int'($urandom_range(0, RMAX)), "R10 rnd");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule